// File: doc/BRIEF.md
# Flash Command Decoder

This block turns host bus writes into the control decisions of a NOR-flash style device. Each cycle with the write strobe high delivers an address and the low eight data bits. The decoder uses them to pick what a read returns: array data, identifier codes, status, or the lock state of a block. It also issues single-cycle start requests for page program, block erase, erase of all unlocked blocks, lock-bit program, suspend, resume, status clear and sleep. An operation controller outside the block reports whether an operation is running (`busy`) and whether it has been suspended (`suspended`). The set of codes the decoder accepts changes with these two inputs and with its own sleep state.

Block erase, erase-all and lock-bit program each take two writes: a setup code, then the confirm code D0h. The address of the confirm write is latched as the operation address. Any other code in the confirm slot raises a sticky sequence-error flag and starts nothing. Page program takes the setup code 41h followed by a fixed number of data writes. Each data write produces a load strobe with its index in the page. The last data write starts the program.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset, `readMode` is array (encoding: 0 array, 1 identifier, 2 status, 3 lock status), no request strobe or load strobe is high, `sleeping` is 0 and `seqErr` is 0.
- R2: When idle (not busy, not suspended, no setup pending), the codes FFh, 90h, 70h and 71h set `readMode` to 0, 1, 2 and 3 after the write's clock edge. Codes that are not commands leave the mode and all strobes unchanged.
- R3: `idCode` is 07h when `hostAddr[0]` is 0. When `hostAddr[0]` is 1, it is 85h with `BOOT_TOP`=1 and 86h with `BOOT_TOP`=0.
- R4: 20h followed by D0h on the next write pulses `startErase` for one cycle after the confirm edge. `opAddr` then holds the confirm write's address and `readMode` is status.
- R5: A7h followed by D0h pulses `startEraseAll`, and 77h followed by D0h pulses `startLockBit`. Both latch `opAddr` as R4 does.
- R6: A setup code (20h, A7h, 77h) followed by any code other than D0h sets `seqErr`, issues no request and sets `readMode` to status. `seqErr` stays set until a 50h write is accepted. That write clears it and pulses `clrStatus`.
- R7: After 41h, the next PAGE_WORDS writes each pulse `loadStrobe`, with `loadIdx` counting 0 to PAGE_WORDS-1. The last of them also pulses `startProg` and latches `opAddr`.
- R8: B0h while busy and not suspended pulses `reqSuspend`. D0h while suspended pulses `reqResume`. Both set `readMode` to status.
- R9: While busy and not suspended, only FFh (array), 70h (status), B0h and F0h take effect. Every other code leaves the mode and all strobes unchanged.
- R10: F0h pulses `reqSleep` and marks sleep pending. `sleeping` rises on the first clock edge without a write at which the decoder is idle and neither busy nor suspended.
- R11: While `sleeping`, every code except FFh is ignored. FFh clears `sleeping` and selects array read.
- R12: While suspended, FFh, 90h, 70h, 71h, 50h, D0h and F0h take effect. Setup codes and B0h are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, also used on powerdown exit |
| wrEn | input | 1 | Host write strobe, one write per cycle |
| hostAddr | input | ADDR_W | Host address |
| wrData | input | 8 | Low data byte of the write |
| busy | input | 1 | Operation controller is running an operation |
| suspended | input | 1 | Running operation is suspended |
| readMode | output | 2 | Read source select |
| idCode | output | 8 | Identifier byte for the current address |
| opAddr | output | ADDR_W | Address latched by confirm or by last page write |
| startProg | output | 1 | Page program start pulse |
| startErase | output | 1 | Block erase start pulse |
| startEraseAll | output | 1 | Erase-all-unlocked start pulse |
| startLockBit | output | 1 | Lock-bit program start pulse |
| reqSuspend | output | 1 | Suspend request pulse |
| reqResume | output | 1 | Resume request pulse |
| clrStatus | output | 1 | Clear status error bits pulse |
| reqSleep | output | 1 | Sleep request pulse |
| sleeping | output | 1 | Decoder is in sleep |
| seqErr | output | 1 | Sticky command-sequence error |
| loadStrobe | output | 1 | Page data word accepted |
| loadIdx | output | $clog2(PAGE_WORDS) | Index of the accepted page word |

## Verification
The bench builds the decoder with an 8-bit address, a 4-word page and bottom boot (device code 86h). The short page lets a full program sequence, including its last-word start, run in a few cycles. The 8-bit address lets every byte code double as its own confirm address. With this setup the bench sweeps all 256 codes through each context: idle, busy, suspended, sleeping, and the confirm slot after an erase setup. Expected modes and strobes come from a small decode table in the bench.

// File: rtl/fcui_pkg.sv
package fcui_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2,
    RM_LOCK   = 2'd3
  } rdMode_e;

  typedef enum logic [2:0] {
    CS_IDLE,
    CS_ERASE,
    CS_ALL,
    CS_LOCKB,
    CS_LOAD,
    CS_SLEEP
  } cuiState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    modeWe;
    rdMode_e modeVal;
    logic    addrWe;
    logic    errSet;
    logic    errClr;
    logic    cntClr;
    logic    cntInc;
  } dpCtl_t;

  typedef struct packed {
    logic prog;
    logic erase;
    logic eraseAll;
    logic lockBit;
    logic suspend;
    logic resume;
    logic clrStat;
    logic sleep;
  } opReq_t;

  localparam logic [7:0] C_ARRAY   = 8'hFF;
  localparam logic [7:0] C_IDENT   = 8'h90;
  localparam logic [7:0] C_STATUS  = 8'h70;
  localparam logic [7:0] C_LOCKRD  = 8'h71;
  localparam logic [7:0] C_CLEAR   = 8'h50;
  localparam logic [7:0] C_PROG    = 8'h41;
  localparam logic [7:0] C_ERASE   = 8'h20;
  localparam logic [7:0] C_ALL     = 8'hA7;
  localparam logic [7:0] C_LOCKBIT = 8'h77;
  localparam logic [7:0] C_CONFIRM = 8'hD0;
  localparam logic [7:0] C_SUSPEND = 8'hB0;
  localparam logic [7:0] C_SLEEP   = 8'hF0;

endpackage

// File: rtl/fcui_ctrl.sv
module fcui_ctrl
  import fcui_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       busy,
  input  logic       suspended,
  input  logic       cntLast,
  output dpCtl_t     ctl,
  output opReq_t     req,
  output logic       loadStrobe,
  output logic       sleeping
);

  cuiState_e state, stateNxt;
  logic      pend, pendNxt;
  opReq_t    reqNxt;
  logic      loadNxt;

  function automatic dpCtl_t setMode(input dpCtl_t c, input rdMode_e m);
    dpCtl_t r;
    r = c;
    r.modeWe  = 1'b1;
    r.modeVal = m;
    return r;
  endfunction

  always_comb begin
    ctl      = '0;
    reqNxt   = '0;
    loadNxt  = 1'b0;
    stateNxt = state;
    pendNxt  = pend;
    if (state == CS_SLEEP) begin
      if (wrEn && wrData == C_ARRAY) begin
        stateNxt = CS_IDLE;
        pendNxt  = 1'b0;
        ctl      = setMode(ctl, RM_ARRAY);
      end
    end else if (wrEn) begin
      unique case (state)
        CS_ERASE, CS_ALL, CS_LOCKB: begin
          stateNxt = CS_IDLE;
          ctl      = setMode(ctl, RM_STATUS);
          if (wrData == C_CONFIRM) begin
            ctl.addrWe      = 1'b1;
            reqNxt.erase    = (state == CS_ERASE);
            reqNxt.eraseAll = (state == CS_ALL);
            reqNxt.lockBit  = (state == CS_LOCKB);
          end else begin
            ctl.errSet = 1'b1;
          end
        end
        CS_LOAD: begin
          ctl.cntInc = 1'b1;
          loadNxt    = 1'b1;
          if (cntLast) begin
            stateNxt    = CS_IDLE;
            ctl.addrWe  = 1'b1;
            reqNxt.prog = 1'b1;
            ctl         = setMode(ctl, RM_STATUS);
          end
        end
        default: begin
          if (busy && !suspended) begin
            case (wrData)
              C_ARRAY:   ctl = setMode(ctl, RM_ARRAY);
              C_STATUS:  ctl = setMode(ctl, RM_STATUS);
              C_SUSPEND: begin
                reqNxt.suspend = 1'b1;
                ctl = setMode(ctl, RM_STATUS);
              end
              C_SLEEP: begin
                reqNxt.sleep = 1'b1;
                pendNxt      = 1'b1;
              end
              default: ;
            endcase
          end else if (suspended) begin
            case (wrData)
              C_ARRAY:   ctl = setMode(ctl, RM_ARRAY);
              C_IDENT:   ctl = setMode(ctl, RM_IDENT);
              C_STATUS:  ctl = setMode(ctl, RM_STATUS);
              C_LOCKRD:  ctl = setMode(ctl, RM_LOCK);
              C_CONFIRM: begin
                reqNxt.resume = 1'b1;
                ctl = setMode(ctl, RM_STATUS);
              end
              C_CLEAR: begin
                reqNxt.clrStat = 1'b1;
                ctl.errClr     = 1'b1;
              end
              C_SLEEP: begin
                reqNxt.sleep = 1'b1;
                pendNxt      = 1'b1;
              end
              default: ;
            endcase
          end else begin
            case (wrData)
              C_ARRAY:   ctl = setMode(ctl, RM_ARRAY);
              C_IDENT:   ctl = setMode(ctl, RM_IDENT);
              C_STATUS:  ctl = setMode(ctl, RM_STATUS);
              C_LOCKRD:  ctl = setMode(ctl, RM_LOCK);
              C_CLEAR: begin
                reqNxt.clrStat = 1'b1;
                ctl.errClr     = 1'b1;
              end
              C_SLEEP: begin
                reqNxt.sleep = 1'b1;
                pendNxt      = 1'b1;
              end
              C_ERASE:   stateNxt = CS_ERASE;
              C_ALL:     stateNxt = CS_ALL;
              C_LOCKBIT: stateNxt = CS_LOCKB;
              C_PROG: begin
                stateNxt   = CS_LOAD;
                ctl.cntClr = 1'b1;
              end
              default: ;
            endcase
          end
        end
      endcase
    end else if (state == CS_IDLE && pend && !busy && !suspended) begin
      stateNxt = CS_SLEEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= CS_IDLE;
      pend       <= 1'b0;
      req        <= '0;
      loadStrobe <= 1'b0;
    end else begin
      state      <= stateNxt;
      pend       <= pendNxt;
      req        <= reqNxt;
      loadStrobe <= loadNxt;
    end
  end

  assign sleeping = (state == CS_SLEEP);

endmodule

// File: rtl/fcui_dpath.sv
module fcui_dpath
  import fcui_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_WORDS = 128,
  parameter bit BOOT_TOP   = 1'b1,
  localparam int CNT_W     = $clog2(PAGE_WORDS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] hostAddr,
  output rdMode_e           modeQ,
  output logic [ADDR_W-1:0] opAddr,
  output logic              seqErr,
  output logic              cntLast,
  output logic [CNT_W-1:0]  loadIdx,
  output logic [7:0]        idCode
);

  localparam logic [7:0] MAKER_CODE = 8'h07;
  localparam logic [7:0] DEV_CODE   = BOOT_TOP ? 8'h85 : 8'h86;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PAGE_WORDS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= RM_ARRAY;
      opAddr  <= '0;
      seqErr  <= 1'b0;
      cnt     <= '0;
      loadIdx <= '0;
    end else begin
      if (ctl.modeWe) modeQ  <= ctl.modeVal;
      if (ctl.addrWe) opAddr <= hostAddr;
      if (ctl.errSet)      seqErr <= 1'b1;
      else if (ctl.errClr) seqErr <= 1'b0;
      if (ctl.cntClr) cnt <= '0;
      else if (ctl.cntInc) begin
        loadIdx <= cnt;
        cnt     <= cnt + 1'b1;
      end
    end
  end

  assign cntLast = (cnt == LAST_IDX);
  assign idCode  = hostAddr[0] ? DEV_CODE : MAKER_CODE;

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import fcui_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int PAGE_WORDS = 128,
  parameter bit BOOT_TOP   = 1'b1,
  localparam int CNT_W     = $clog2(PAGE_WORDS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        wrData,
  input  logic              busy,
  input  logic              suspended,
  output logic [1:0]        readMode,
  output logic [7:0]        idCode,
  output logic [ADDR_W-1:0] opAddr,
  output logic              startProg,
  output logic              startErase,
  output logic              startEraseAll,
  output logic              startLockBit,
  output logic              reqSuspend,
  output logic              reqResume,
  output logic              clrStatus,
  output logic              reqSleep,
  output logic              sleeping,
  output logic              seqErr,
  output logic              loadStrobe,
  output logic [CNT_W-1:0]  loadIdx
);

  dpCtl_t  ctl;
  opReq_t  req;
  rdMode_e modeQ;
  logic    cntLast;

  fcui_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .busy       (busy),
    .suspended  (suspended),
    .cntLast    (cntLast),
    .ctl        (ctl),
    .req        (req),
    .loadStrobe (loadStrobe),
    .sleeping   (sleeping)
  );

  fcui_dpath #(
    .ADDR_W     (ADDR_W),
    .PAGE_WORDS (PAGE_WORDS),
    .BOOT_TOP   (BOOT_TOP)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .hostAddr (hostAddr),
    .modeQ    (modeQ),
    .opAddr   (opAddr),
    .seqErr   (seqErr),
    .cntLast  (cntLast),
    .loadIdx  (loadIdx),
    .idCode   (idCode)
  );

  assign readMode      = modeQ;
  assign startProg     = req.prog;
  assign startErase    = req.erase;
  assign startEraseAll = req.eraseAll;
  assign startLockBit  = req.lockBit;
  assign reqSuspend    = req.suspend;
  assign reqResume     = req.resume;
  assign clrStatus     = req.clrStat;
  assign reqSleep      = req.sleep;

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       busy,
  input logic       suspended,
  input logic [1:0] readMode,
  input logic       startProg,
  input logic       startErase,
  input logic       startEraseAll,
  input logic       startLockBit,
  input logic       reqSuspend,
  input logic       reqResume,
  input logic       clrStatus,
  input logic       reqSleep,
  input logic       sleeping,
  input logic       seqErr
);

  // R9
  one_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startProg, startErase, startEraseAll, startLockBit,
              reqSuspend, reqResume, clrStatus, reqSleep}));

  // R4
  start_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startProg || startErase || startEraseAll || startLockBit || reqResume)
      |-> readMode == 2'd2);

  // R4
  erase_confirm_chk: assert property (@(posedge clk) disable iff (!rstN)
    startErase |-> $past(wrEn && wrData == 8'hD0));

  // R8
  suspend_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqSuspend |-> $past(busy && !suspended));

  // R6
  seq_err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqErr) |-> $past(wrEn && wrData != 8'hD0));

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleeping && !(wrEn && wrData == 8'hFF)) |=> sleeping);

endmodule

bind flash_cmd_if flash_cmd_if_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .wrEn          (wrEn),
  .wrData        (wrData),
  .busy          (busy),
  .suspended     (suspended),
  .readMode      (readMode),
  .startProg     (startProg),
  .startErase    (startErase),
  .startEraseAll (startEraseAll),
  .startLockBit  (startLockBit),
  .reqSuspend    (reqSuspend),
  .reqResume     (reqResume),
  .clrStatus     (clrStatus),
  .reqSleep      (reqSleep),
  .sleeping      (sleeping),
  .seqErr        (seqErr)
);

// File: tb/tb_flash_cmd_if.sv
`timescale 1ns/1ps
module tb_flash_cmd_if;

  localparam int AW = 8;
  localparam int PW = 4;
  localparam int CW = $clog2(PW);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0] wrData = '0;
  logic busy = 1'b0;
  logic suspended = 1'b0;
  logic [1:0] readMode;
  logic [7:0] idCode;
  logic [AW-1:0] opAddr;
  logic startProg, startErase, startEraseAll, startLockBit;
  logic reqSuspend, reqResume, clrStatus, reqSleep;
  logic sleeping, seqErr, loadStrobe;
  logic [CW-1:0] loadIdx;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_if #(.ADDR_W(AW), .PAGE_WORDS(PW), .BOOT_TOP(1'b0)) dut (.*);

  // {prog, erase, eraseAll, lockBit, suspend, resume, clrStatus, sleep}
  function automatic logic [7:0] strobes();
    return {startProg, startErase, startEraseAll, startLockBit,
            reqSuspend, reqResume, clrStatus, reqSleep};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0; busy = 1'b0; suspended = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; hostAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog (R1..): actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int em;
    int es;
    doReset();
    // R1 reset state
    check("R1 mode", readMode, 0);
    check("R1 strobes", strobes(), 0);
    check("R1 sleeping", sleeping, 0);
    check("R1 seqErr", seqErr, 0);
    check("R1 load", loadStrobe, 0);

    // R3 identifier codes
    hostAddr = 8'h00; #1;
    check("R3 maker", idCode, 8'h07);
    hostAddr = 8'h01; #1;
    check("R3 device", idCode, 8'h86);

    // R2 idle sweep
    for (int c = 0; c < 256; c++) begin
      doReset();
      wr(0, 8'h90);
      wr(0, 8'(c));
      em = (c == 8'hFF) ? 0 : (c == 8'h90) ? 1 : (c == 8'h70) ? 2 :
           (c == 8'h71) ? 3 : 1;
      es = (c == 8'h50) ? 8'h02 : (c == 8'hF0) ? 8'h01 : 0;
      check($sformatf("R2 mode code %02h", c), readMode, em);
      check($sformatf("R2 strobe code %02h", c), strobes(), es);
    end

    // R4 / R6 confirm slot sweep
    for (int c = 0; c < 256; c++) begin
      doReset();
      wr(0, 8'h20);
      wr(8'(c), 8'(c));
      check($sformatf("R4 mode code %02h", c), readMode, 2);
      if (c == 8'hD0) begin
        check("R4 strobe", strobes(), 8'h40);
        check("R4 opAddr", opAddr, 8'hD0);
        check("R4 seqErr", seqErr, 0);
      end else begin
        check($sformatf("R6 strobe code %02h", c), strobes(), 0);
        check($sformatf("R6 seqErr code %02h", c), seqErr, 1);
      end
    end

    // R6 sticky then cleared by 50h
    doReset();
    wr(0, 8'h77); wr(0, 8'h12);
    wr(0, 8'hFF);
    check("R6 sticky", seqErr, 1);
    wr(0, 8'h50);
    check("R6 clear strobe", strobes(), 8'h02);
    check("R6 cleared", seqErr, 0);

    // R5 erase-all and lock-bit
    doReset();
    wr(0, 8'hA7); wr(8'h05, 8'hD0);
    check("R5 eraseAll", strobes(), 8'h20);
    check("R5 opAddr all", opAddr, 8'h05);
    wr(0, 8'h77); wr(8'h9A, 8'hD0);
    check("R5 lockBit", strobes(), 8'h10);
    check("R5 opAddr lock", opAddr, 8'h9A);

    // R7 page load
    doReset();
    wr(0, 8'h41);
    for (int i = 0; i < PW; i++) begin
      wr(8'(8'h30 + i), 8'(i * 3));
      check("R7 loadStrobe", loadStrobe, 1);
      check("R7 loadIdx", loadIdx, i);
      check("R7 prog", startProg, (i == PW - 1) ? 1 : 0);
    end
    check("R7 opAddr", opAddr, 8'h30 + PW - 1);
    check("R7 mode", readMode, 2);
    idle(1);
    check("R7 load ends", loadStrobe, 0);

    // R9 / R8 busy sweep
    for (int c = 0; c < 256; c++) begin
      doReset();
      wr(0, 8'h90);
      busy = 1'b1;
      wr(0, 8'(c));
      em = (c == 8'hFF) ? 0 : (c == 8'h70 || c == 8'hB0) ? 2 : 1;
      es = (c == 8'hB0) ? 8'h08 : (c == 8'hF0) ? 8'h01 : 0;
      check($sformatf("R9 mode code %02h", c), readMode, em);
      check($sformatf("R9 strobe code %02h", c), strobes(), es);
    end

    // R12 / R8 suspended sweep
    for (int c = 0; c < 256; c++) begin
      doReset();
      wr(0, 8'h90);
      busy = 1'b1; suspended = 1'b1;
      wr(0, 8'(c));
      em = (c == 8'hFF) ? 0 : (c == 8'h90) ? 1 : (c == 8'h70) ? 2 :
           (c == 8'h71) ? 3 : (c == 8'hD0) ? 2 : 1;
      es = (c == 8'hD0) ? 8'h04 : (c == 8'h50) ? 8'h02 :
           (c == 8'hF0) ? 8'h01 : 0;
      check($sformatf("R12 mode code %02h", c), readMode, em);
      check($sformatf("R12 strobe code %02h", c), strobes(), es);
    end

    // R10 sleep deferred while busy
    doReset();
    busy = 1'b1;
    wr(0, 8'hF0);
    check("R10 reqSleep", strobes(), 8'h01);
    idle(3);
    check("R10 not yet", sleeping, 0);
    busy = 1'b0;
    idle(1);
    check("R10 asleep", sleeping, 1);

    // R11 sleep sweep
    doReset();
    wr(0, 8'h70);
    wr(0, 8'hF0);
    idle(1);
    check("R11 entered", sleeping, 1);
    for (int c = 0; c < 255; c++) begin
      wr(0, 8'(c));
      check($sformatf("R11 stay code %02h", c), sleeping, 1);
      check($sformatf("R11 mode code %02h", c), readMode, 2);
      check($sformatf("R11 strobe code %02h", c), strobes(), 0);
    end
    wr(0, 8'hFF);
    check("R11 wake", sleeping, 0);
    check("R11 array", readMode, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule